// File: doc/BRIEF.md
# Sparse Pulse Convolution Engine

This engine filters a sparse excitation through a stored impulse response. The excitation has only five or six non-zero pulses among sixty sample positions. Looping over all sixty positions for every output would waste most of the multiplies. Instead, the engine visits only the stored pulses for each output sample. For pulse j and output index l, it reads the impulse response at offset l minus the pulse position. A pulse that lies after the current output index cannot contribute. The address generator detects this from the sign of that subtraction. That sign bit then forces the multiplier operand to zero and suppresses the memory read, so no branch is needed and no read falls outside the buffer.

Software or a search controller first writes the pulse slots and the sixty-entry impulse response, then pulses `start`. The engine produces sixty results, from index 59 down to index 0, on a write port, and then raises `done` for one cycle. A second address mode uses the magnitude of the offset instead of gating it. In that mode the stored response is read as a symmetric (even) sequence.

Top module: `spconv_engine`

## Requirements
- R1: After the edge that accepts `start` (edge 0), exactly 60 results appear on the write port, with `out_we` high for one cycle each, in the order `out_idx` = 59, 58, ..., 0. The result for index 59-k is visible after edge k*N+N+1, where N is the number of pulses in use.
- R2: If `odd_sel` is 1 when `start` is accepted, only pulse slots 0 to 4 are used (N=5), and slot 5 has no effect. If `odd_sel` is 0, slots 0 to 5 are used (N=6).
- R3: Each pulse term is the 16x16 signed product doubled, and the sum is saturated to 32 bits. The product of -32768 and -32768 becomes 0x7FFFFFFF. An accumulation that passes 0x7FFFFFFF or 0x80000000 clamps at that limit.
- R4: With `sym_sel`=0, the read offset is l minus the pulse position, and the memory address is IR_BASE plus that offset. When the offset is negative, the term adds zero and no memory read is issued.
- R5: The accumulator starts from zero for every output index, so each result depends only on that index's own terms.
- R6: Each result is the 32-bit sum shifted left by two and saturated to 0x7FFFFFFF or 0x80000000 on overflow, then reduced to its upper 16 bits.
- R7: With `sym_sel`=1 when `start` is accepted, the read offset is the absolute value of l minus the pulse position, and no term is gated.
- R8: `done` is a one-cycle pulse in the cycle after the result for index 0 is written. `busy` falls in that same cycle.
- R9: While `busy` is high, `start`, pulse-slot writes and impulse-response writes are ignored.
- R10: After reset, `busy`, `done` and `out_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pls_we | input | 1 | Write one pulse slot |
| pls_slot | input | PIW (3) | Pulse slot number, 0 to MAXP-1 |
| pls_pos | input | IW (6) | Pulse position, 0 to 59 |
| pls_amp | input | 16 | Signed pulse amplitude |
| ir_we | input | 1 | Write one impulse-response sample |
| ir_idx | input | IW (6) | Impulse-response sample index, 0 to 59 |
| ir_val | input | 16 | Signed impulse-response sample |
| start | input | 1 | Begin a 60-output pass |
| odd_sel | input | 1 | Use five pulses instead of six |
| sym_sel | input | 1 | Use the magnitude of the offset, with no gating |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| out_we | output | 1 | Result valid |
| out_idx | output | IW (6) | Output index of the result |
| out_data | output | 16 | Signed result |

## Verification
The bench places pulses after late output indices, so for most indices some terms must be gated. A design that read memory for those terms would fold in wrapped or unwritten samples, and the wrong or unknown values would show up in the results. Runs with every product at -32768 times -32768 exercise the product, sum and shift saturation. A design that wrapped instead would flip the sign of the results. An odd-mode run leaves a large amplitude in slot 5, so a six-pulse loop is exposed both by a cycle offset and by wrong data. A run that pulses `start` and rewrites memories partway through catches a design that restarts, or that lets those writes change results still to come.

// File: rtl/spconv_pkg.sv
package spconv_pkg;

  localparam int DW   = 16;
  localparam int ACCW = 32;

  localparam logic signed [ACCW-1:0] ACC_MAX = 32'sh7fffffff;
  localparam logic signed [ACCW-1:0] ACC_MIN = 32'sh80000000;

  // doubled 16x16 product added to a saturating 32-bit accumulator
  function automatic logic signed [ACCW-1:0] frac_mac(
    input logic signed [ACCW-1:0] acc,
    input logic signed [DW-1:0]   a,
    input logic signed [DW-1:0]   b
  );
    logic signed [ACCW-1:0] prod;
    logic signed [ACCW:0]   sum;
    if (a == 16'sh8000 && b == 16'sh8000) begin
      prod = ACC_MAX;
    end else begin
      prod = (32'(a) * 32'(b)) <<< 1;
    end
    sum = {acc[ACCW-1], acc} + {prod[ACCW-1], prod};
    if (sum[ACCW] != sum[ACCW-1]) begin
      frac_mac = sum[ACCW] ? ACC_MIN : ACC_MAX;
    end else begin
      frac_mac = sum[ACCW-1:0];
    end
  endfunction

  // left shift by two with clamping when bits would be lost
  function automatic logic signed [ACCW-1:0] shl2_sat(input logic signed [ACCW-1:0] v);
    if ((v[ACCW-1:ACCW-3] == 3'b000) || (v[ACCW-1:ACCW-3] == 3'b111)) begin
      shl2_sat = v <<< 2;
    end else begin
      shl2_sat = v[ACCW-1] ? ACC_MIN : ACC_MAX;
    end
  endfunction

  function automatic logic signed [DW-1:0] hi_half(input logic signed [ACCW-1:0] v);
    hi_half = v[ACCW-1:ACCW-DW];
  endfunction

endpackage

// File: rtl/spconv_pulse_regs.sv
module spconv_pulse_regs #(
  parameter int MAXP = 6,
  parameter int IW   = 6,
  parameter int DW   = 16,
  localparam int PIW = $clog2(MAXP)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [PIW-1:0]       wr_slot,
  input  logic [IW-1:0]        wr_pos,
  input  logic signed [DW-1:0] wr_amp,
  input  logic [PIW-1:0]       rd_slot,
  output logic [IW-1:0]        rd_pos,
  output logic signed [DW-1:0] rd_amp
);

  logic [IW-1:0]        pos_q [MAXP];
  logic signed [DW-1:0] amp_q [MAXP];

  for (genvar g = 0; g < MAXP; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pos_q[g] <= '0;
        amp_q[g] <= '0;
      end else if (wr_en && (wr_slot == PIW'(g))) begin
        pos_q[g] <= wr_pos;
        amp_q[g] <= wr_amp;
      end
    end
  end

  always_comb begin
    rd_pos = '0;
    rd_amp = '0;
    for (int i = 0; i < MAXP; i++) begin
      if (rd_slot == PIW'(i)) begin
        rd_pos = pos_q[i];
        rd_amp = amp_q[i];
      end
    end
  end

endmodule

// File: rtl/spconv_ir_mem.sv
module spconv_ir_mem #(
  parameter int DEPTH = 64,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic signed [DW-1:0] wr_data,
  input  logic                 rd_en,
  input  logic [AW-1:0]        rd_addr,
  output logic signed [DW-1:0] rd_data
);

  logic signed [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/spconv_agen.sv
module spconv_agen #(
  parameter int IW      = 6,
  parameter int MAW     = 6,
  parameter int IR_BASE = 4
) (
  input  logic [IW-1:0]  loop_cnt,
  input  logic [IW-1:0]  pulse_pos,
  input  logic           sym,
  output logic [MAW-1:0] addr,
  output logic           neg_gate
);

  logic [IW:0]   diff;
  logic [IW:0]   mag;
  logic [IW-1:0] offs;

  always_comb begin
    diff     = {1'b0, loop_cnt} - {1'b0, pulse_pos};
    mag      = diff[IW] ? (~diff + 1'b1) : diff;
    offs     = sym ? mag[IW-1:0] : diff[IW-1:0];
    addr     = MAW'(IR_BASE) + MAW'(offs);
    neg_gate = diff[IW] & ~sym;
  end

endmodule

// File: rtl/spconv_mac.sv
module spconv_mac
  import spconv_pkg::*;
#(
  parameter int IW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s1_v,
  input  logic                 s1_first,
  input  logic                 s1_last,
  input  logic                 s1_gate,
  input  logic [IW-1:0]        s1_idx,
  input  logic signed [DW-1:0] s1_amp,
  input  logic signed [DW-1:0] mem_data,
  output logic                 out_we,
  output logic [IW-1:0]        out_idx,
  output logic signed [DW-1:0] out_data
);

  logic signed [ACCW-1:0] acc_q;
  logic signed [ACCW-1:0] acc_base;
  logic signed [ACCW-1:0] acc_nx;
  logic signed [DW-1:0]   opnd;

  always_comb begin
    opnd     = s1_gate ? '0 : mem_data;
    acc_base = s1_first ? '0 : acc_q;
    acc_nx   = frac_mac(acc_base, s1_amp, opnd);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q    <= '0;
      out_we   <= 1'b0;
      out_idx  <= '0;
      out_data <= '0;
    end else begin
      out_we <= s1_v && s1_last;
      if (s1_v) acc_q <= acc_nx;
      if (s1_v && s1_last) begin
        out_idx  <= s1_idx;
        out_data <= hi_half(shl2_sat(acc_nx));
      end
    end
  end

  p_out_after_last_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> $past(s1_v && s1_last));

  p_first_restarts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && s1_first && s1_gate) |=> (acc_q == '0));

endmodule

// File: rtl/spconv_engine.sv
module spconv_engine
  import spconv_pkg::*;
#(
  parameter int NSAMP   = 60,
  parameter int MAXP    = 6,
  parameter int IR_BASE = 4,
  localparam int IW     = $clog2(NSAMP),
  localparam int PIW    = $clog2(MAXP)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pls_we,
  input  logic [PIW-1:0]       pls_slot,
  input  logic [IW-1:0]        pls_pos,
  input  logic signed [15:0]   pls_amp,
  input  logic                 ir_we,
  input  logic [IW-1:0]        ir_idx,
  input  logic signed [15:0]   ir_val,
  input  logic                 start,
  input  logic                 odd_sel,
  input  logic                 sym_sel,
  output logic                 busy,
  output logic                 done,
  output logic                 out_we,
  output logic [IW-1:0]        out_idx,
  output logic signed [15:0]   out_data
);

  localparam int MEM_DEPTH = IR_BASE + NSAMP;
  localparam int MAW       = $clog2(MEM_DEPTH);

  // issue stage
  logic           iss_v;
  logic [IW-1:0]  l_q;
  logic [PIW-1:0] j_q;
  logic           odd_q;
  logic           sym_q;
  logic           j_last;
  logic           last_out;

  logic [IW-1:0]        cur_pos;
  logic signed [DW-1:0] cur_amp;
  logic [MAW-1:0]       rd_addr;
  logic                 neg_gate;
  logic                 rd_en;

  // MAC stage
  logic                 s1_v;
  logic                 s1_first;
  logic                 s1_last;
  logic                 s1_gate;
  logic [IW-1:0]        s1_idx;
  logic signed [DW-1:0] s1_amp;
  logic signed [DW-1:0] mem_data;

  assign j_last   = (j_q == (odd_q ? PIW'(MAXP-2) : PIW'(MAXP-1)));
  assign last_out = out_we && (out_idx == '0);
  assign rd_en    = iss_v && !neg_gate;

  spconv_pulse_regs #(.MAXP(MAXP), .IW(IW), .DW(DW)) i_pulses (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (pls_we && !busy),
    .wr_slot (pls_slot),
    .wr_pos  (pls_pos),
    .wr_amp  (pls_amp),
    .rd_slot (j_q),
    .rd_pos  (cur_pos),
    .rd_amp  (cur_amp)
  );

  spconv_agen #(.IW(IW), .MAW(MAW), .IR_BASE(IR_BASE)) i_agen (
    .loop_cnt  (l_q),
    .pulse_pos (cur_pos),
    .sym       (sym_q),
    .addr      (rd_addr),
    .neg_gate  (neg_gate)
  );

  spconv_ir_mem #(.DEPTH(MEM_DEPTH), .DW(DW)) i_ir (
    .clk     (clk),
    .wr_en   (ir_we && !busy),
    .wr_addr (MAW'(IR_BASE) + MAW'(ir_idx)),
    .wr_data (ir_val),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (mem_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      iss_v <= 1'b0;
      l_q   <= '0;
      j_q   <= '0;
      odd_q <= 1'b0;
      sym_q <= 1'b0;
    end else begin
      done <= last_out;
      if (last_out) busy <= 1'b0;
      if (start && !busy) begin
        busy  <= 1'b1;
        iss_v <= 1'b1;
        l_q   <= IW'(NSAMP-1);
        j_q   <= '0;
        odd_q <= odd_sel;
        sym_q <= sym_sel;
      end else if (iss_v) begin
        if (j_last) begin
          j_q <= '0;
          if (l_q == '0) iss_v <= 1'b0;
          else           l_q   <= l_q - 1'b1;
        end else begin
          j_q <= j_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v     <= 1'b0;
      s1_first <= 1'b0;
      s1_last  <= 1'b0;
      s1_gate  <= 1'b0;
      s1_idx   <= '0;
      s1_amp   <= '0;
    end else begin
      s1_v     <= iss_v;
      s1_first <= (j_q == '0);
      s1_last  <= j_last;
      s1_gate  <= neg_gate;
      s1_idx   <= l_q;
      s1_amp   <= cur_amp;
    end
  end

  spconv_mac #(.IW(IW)) i_mac (
    .clk      (clk),
    .rst_n    (rst_n),
    .s1_v     (s1_v),
    .s1_first (s1_first),
    .s1_last  (s1_last),
    .s1_gate  (s1_gate),
    .s1_idx   (s1_idx),
    .s1_amp   (s1_amp),
    .mem_data (mem_data),
    .out_we   (out_we),
    .out_idx  (out_idx),
    .out_data (out_data)
  );

  p_addr_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> ((int'(rd_addr) >= IR_BASE) && (int'(rd_addr) < IR_BASE + NSAMP)));

  p_gated_no_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && s1_gate) |-> $past(!rd_en));

  p_sym_never_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_v && sym_q) |-> !neg_gate);

  p_done_after_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(out_we) && ($past(out_idx) == '0) && !busy));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last_out) |=> busy);

  p_out_in_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> busy);

endmodule

// File: tb/test_spconv_engine.sv
module test_spconv_engine;

  localparam int NS = 60;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pls_we = 1'b0;
  logic [2:0]  pls_slot = '0;
  logic [5:0]  pls_pos = '0;
  logic signed [15:0] pls_amp = '0;
  logic        ir_we = 1'b0;
  logic [5:0]  ir_idx = '0;
  logic signed [15:0] ir_val = '0;
  logic        start = 1'b0;
  logic        odd_sel = 1'b0;
  logic        sym_sel = 1'b0;
  logic        busy, done, out_we;
  logic [5:0]  out_idx;
  logic signed [15:0] out_data;

  int checks = 0;
  int errors = 0;
  int hpos [6];
  int hamp [6];
  int hir  [NS];
  int expv [NS];

  always #2.5 clk = ~clk;

  spconv_engine i_spconv_engine (
    .clk(clk), .rst_n(rst_n), .pls_we(pls_we), .pls_slot(pls_slot),
    .pls_pos(pls_pos), .pls_amp(pls_amp), .ir_we(ir_we), .ir_idx(ir_idx),
    .ir_val(ir_val), .start(start), .odd_sel(odd_sel), .sym_sel(sym_sel),
    .busy(busy), .done(done), .out_we(out_we), .out_idx(out_idx),
    .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic longint clamp32(input longint v);
    if (v > 64'sd2147483647) return 64'sd2147483647;
    if (v < -64'sd2147483648) return -64'sd2147483648;
    return v;
  endfunction

  // behavioural model of one output sample
  function automatic int model(input int l, input int n, input bit sym);
    longint acc = 0;
    longint prod;
    longint sh;
    for (int j = 0; j < n; j++) begin
      int off = l - hpos[j];
      if (sym && off < 0) off = -off;
      if (off < 0) continue;
      if (hamp[j] == -32768 && hir[off] == -32768) prod = 64'sd2147483647;
      else prod = 2 * longint'(hamp[j]) * longint'(hir[off]);
      acc = clamp32(acc + prod);
    end
    sh = clamp32(acc * 4);
    return int'(sh >>> 16);
  endfunction

  task automatic put_pulse(input int s, input int p, input int a);
    @(negedge clk);
    pls_we = 1'b1; pls_slot = 3'(s); pls_pos = 6'(p); pls_amp = 16'(a);
    hpos[s] = p; hamp[s] = a;
    @(negedge clk);
    pls_we = 1'b0;
  endtask

  task automatic put_ir(input int i, input int v);
    @(negedge clk);
    ir_we = 1'b1; ir_idx = 6'(i); ir_val = 16'(v);
    hir[i] = v;
    @(negedge clk);
    ir_we = 1'b0;
  endtask

  // one pass, checked on every cycle against the schedule of R1/R8
  task automatic run(input bit odd, input bit sym, input bit disturb, input string tag);
    int n = odd ? 5 : 6;
    int endc = 60 * n + 2;
    for (int l = 0; l < NS; l++) expv[l] = model(l, n, sym);
    @(negedge clk);
    odd_sel = odd; sym_sel = sym; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc <= endc + 2; cyc++) begin
      bit ew = (cyc >= n + 1) && ((cyc - 1) % n == 0) && ((cyc - 1) / n - 1 <= 59);
      int eidx = 59 - ((cyc - 1) / n - 1);
      chk(out_we === ew, {"R1 out_we ", tag}, longint'(out_we), longint'(ew));
      chk(done === (cyc == endc), {"R8 done ", tag}, longint'(done), longint'(cyc == endc));
      chk(busy === (cyc < endc), {"R8 busy ", tag}, longint'(busy), longint'(cyc < endc));
      if (ew && out_we === 1'b1) begin
        chk(int'(out_idx) == eidx, {"R1 index ", tag}, longint'(out_idx), longint'(eidx));
        chk(int'(out_data) == expv[eidx],
            {"R3 R4 R5 R6 data ", tag}, longint'(out_data), longint'(expv[eidx]));
      end
      if (disturb && cyc == 50) begin
        // R9: these must neither restart nor alter the running pass
        start = 1'b1; pls_we = 1'b1; pls_slot = 3'd0; pls_pos = 6'd0; pls_amp = 16'sd12345;
        ir_we = 1'b1; ir_idx = 6'd0; ir_val = 16'sd30000;
      end
      if (disturb && cyc == 52) begin
        start = 1'b0; pls_we = 1'b0; ir_we = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0, "R10 busy", longint'(busy), 0);
    chk(done === 1'b0, "R10 done", longint'(done), 0);
    chk(out_we === 1'b0, "R10 out_we", longint'(out_we), 0);

    for (int i = 0; i < NS; i++) put_ir(i, ((i * 1237 + 311) % 8000) - 4000);
    put_pulse(0, 3, 9000);
    put_pulse(1, 17, -12000);
    put_pulse(2, 29, 7000);
    put_pulse(3, 41, -3000);
    put_pulse(4, 52, 15000);
    put_pulse(5, 59, -20000);
    run(1'b0, 1'b0, 1'b0, "even causal R4 R5");

    // R2: slot 5 holds a large amplitude that must not count
    put_pulse(5, 0, 32000);
    run(1'b1, 1'b0, 1'b0, "odd R2");

    // R7: magnitude addressing
    run(1'b0, 1'b1, 1'b0, "symmetric R7");

    // R3/R6: saturating products, sums and shift
    for (int i = 0; i < NS; i++) put_ir(i, -32768);
    for (int s = 0; s < 6; s++) put_pulse(s, s * 10, -32768);
    run(1'b0, 1'b0, 1'b0, "saturate neg R3 R6");
    for (int s = 0; s < 6; s++) put_pulse(s, s, 16384);
    for (int i = 0; i < NS; i++) put_ir(i, (i % 2 == 0) ? 16384 : -16384);
    run(1'b0, 1'b0, 1'b0, "saturate shift R6");

    // R9: disturbances while busy
    for (int i = 0; i < NS; i++) put_ir(i, ((i * 577 + 91) % 6000) - 3000);
    put_pulse(0, 1, -8000);
    put_pulse(1, 22, 11000);
    put_pulse(2, 35, -5000);
    put_pulse(3, 58, 4000);
    put_pulse(4, 44, 6000);
    put_pulse(5, 9, -7000);
    run(1'b0, 1'b0, 1'b1, "busy ignore R9");
    run(1'b1, 1'b1, 1'b0, "odd symmetric R2 R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule